// File: doc/BRIEF.md
# Token and Start-of-Frame Packet Builder

This block builds the short packets a serial-bus host controller issues to direct traffic: token packets that name a device address and endpoint, and start-of-frame packets that carry a frame number. On a start strobe it takes a 4-bit packet type and either the address and endpoint fields or the frame number. It forms the identifier byte: the type in the low nibble and its bitwise inverse in the high nibble. It then streams out the identifier, the 11 payload bits and a 5-bit check code, one bit per handshake, to a downstream line encoder.

The output is a valid/ready bit stream. The block raises `bit_valid_o` for every bit of a packet and holds `bit_o` steady until the consumer takes it with `bit_ready_i`. Back-pressure may last any number of cycles. A bit is consumed on each clock edge where valid and ready are both high. Only 24 accepted bits end a packet. The check code is built bit by bit while the payload leaves, so a stall costs nothing but the stall. A request with a type code that is not one of the four packet kinds produces a one-cycle error pulse and no packet.

Top module: `tok_sof_builder`

## Requirements
- R1: After reset `busy_o`, `bit_valid_o` and `err_o` are all low.
- R2: The first 8 bits of a packet are the identifier byte, least significant bit first. Its low nibble is `pkt_type_i` and its high nibble is the inverse of `pkt_type_i`. The legal type codes are 4'h1 (out token), 4'h9 (in token), 4'hD (setup token) and 4'h5 (start of frame).
- R3: For the three token types, bits 8 to 14 of the stream are `addr_i` least significant bit first, and bits 15 to 18 are `endp_i` least significant bit first.
- R4: For type 4'h5, bits 8 to 18 are `frame_i` least significant bit first, and `addr_i`/`endp_i` have no effect on the stream.
- R5: Bits 19 to 23 are the check code. It is computed over stream bits 8 to 18 in send order with generator x^5+x^2+1, starting from all ones. The code is sent inverted, most significant bit first.
- R6: While `bit_valid_o` is high and `bit_ready_i` is low, `bit_valid_o` stays high and `bit_o` keeps its value into the next cycle.
- R7: `busy_o` and `bit_valid_o` rise in the cycle after an accepted legal start. They fall in the cycle after the 24th bit is accepted.
- R8: A start request while `busy_o` is high is ignored. This includes the cycle in which the last bit is accepted: no second packet follows.
- R9: A start with any other type code sets `err_o` high for exactly the next cycle, and `busy_o` and `bit_valid_o` stay low.
- R10: Field and type inputs are captured at the accepted start. Changing them during a packet does not alter that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to build a packet, taken when not busy |
| pkt_type_i | input | 4 | Packet type code |
| addr_i | input | 7 | Device address for token packets |
| endp_i | input | 4 | Endpoint number for token packets |
| frame_i | input | 11 | Frame number for start-of-frame packets |
| busy_o | output | 1 | A packet is in progress |
| err_o | output | 1 | One-cycle pulse for a start with an illegal type |
| bit_o | output | 1 | Current stream bit |
| bit_valid_o | output | 1 | `bit_o` is valid |
| bit_ready_i | input | 1 | Consumer takes `bit_o` this cycle |

## Verification
Acceptance of the final check-code bit and a new start request can fall in the same cycle. The bench holds `start_i` high, with a legal type, through the whole body of every packet, so the request is present on the edge where the 24th bit is taken. In the following cycle `busy_o` and `bit_valid_o` must both be low, which shows that the request was dropped and not queued. The bench also pulls the field inputs away from their captured values during the packet and compares all 24 received bits with an arithmetically computed stream, under steady, alternating and random back-pressure.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int TYPE_W  = 4;
  localparam int ADDR_W  = 7;
  localparam int ENDP_W  = 4;
  localparam int FRAME_W = ADDR_W + ENDP_W;
  localparam int CRC_W   = 5;
  localparam int PID_W   = 2 * TYPE_W;
  localparam int PAY_W   = FRAME_W;
  localparam int PKT_W   = PID_W + PAY_W + CRC_W;
  localparam int CNT_W   = $clog2(PKT_W);

  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;

  localparam logic [TYPE_W-1:0] TY_OUT   = 4'h1;
  localparam logic [TYPE_W-1:0] TY_IN    = 4'h9;
  localparam logic [TYPE_W-1:0] TY_SETUP = 4'hD;
  localparam logic [TYPE_W-1:0] TY_SOF   = 4'h5;

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_BODY, PH_CHK} phase_t;
endpackage

// File: rtl/tsb_pid_encode.sv
module tsb_pid_encode
  import tsb_pkg::*;
(
  input  logic [TYPE_W-1:0] type_i,
  output logic              legal_o,
  output logic              frame_o,
  output logic [PID_W-1:0]  pid_o
);
  always_comb begin
    legal_o = 1'b0;
    frame_o = 1'b0;
    case (type_i)
      TY_OUT, TY_IN, TY_SETUP: legal_o = 1'b1;
      TY_SOF: begin
        legal_o = 1'b1;
        frame_o = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
    pid_o = {~type_i, type_i};
  end
endmodule

// File: rtl/tsb_crc_serial.sv
module tsb_crc_serial #(
  parameter int                W    = 5,
  parameter logic [W-1:0]      POLY = 5'b00101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         step_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= '1;
    else if (init_i)   crc_q <= '1;
    else if (step_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ ((crc_q[W-1] ^ din_i) ? POLY : '0);
    else if (shift_i)  crc_q <= {crc_q[W-2:0], 1'b0};
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/tsb_shift.sv
module tsb_shift #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (adv_i)   sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/tok_sof_builder.sv
module tok_sof_builder
  import tsb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [TYPE_W-1:0]  pkt_type_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ENDP_W-1:0]  endp_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               bit_o,
  output logic               bit_valid_o,
  input  logic               bit_ready_i
);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(PID_W);
  localparam logic [CNT_W-1:0] BODY_END = CNT_W'(PID_W + PAY_W);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(PKT_W - 1);

  logic              legal, is_frame;
  logic [PID_W-1:0]  pid;
  logic [PAY_W-1:0]  payload;
  logic              busy_q, err_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept, load, fire, sh_bit;
  logic [CRC_W-1:0]  crc;
  phase_t            phase;

  tsb_pid_encode u_pid (
    .type_i (pkt_type_i),
    .legal_o(legal),
    .frame_o(is_frame),
    .pid_o  (pid)
  );

  assign payload = is_frame ? frame_i : {endp_i, addr_i};
  assign accept  = start_i & ~busy_q;
  assign load    = accept & legal;
  assign fire    = busy_q & bit_ready_i;

  always_comb begin
    if (!busy_q)                phase = PH_IDLE;
    else if (cnt_q < HDR_END)   phase = PH_HDR;
    else if (cnt_q < BODY_END)  phase = PH_BODY;
    else                        phase = PH_CHK;
  end

  tsb_shift #(.W(PID_W + PAY_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .adv_i (fire && (phase != PH_CHK)),
    .data_i({payload, pid}),
    .bit_o (sh_bit)
  );

  tsb_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (load),
    .step_i (fire && (phase == PH_BODY)),
    .shift_i(fire && (phase == PH_CHK)),
    .din_i  (sh_bit),
    .crc_o  (crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      err_q <= accept & ~legal;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (fire) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign bit_valid_o = busy_q;
  assign bit_o       = (phase == PH_CHK) ? ~crc[CRC_W-1] : (busy_q & sh_bit);
endmodule

// File: rtl/tsb_chk.sv
module tsb_chk
  import tsb_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic err_o,
  input logic bit_o,
  input logic bit_valid_o,
  input logic bit_ready_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);
  logic [CNT_W-1:0] taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           taken_q <= '0;
    else if (!busy_o)                     taken_q <= '0;
    else if (bit_valid_o && bit_ready_i)  taken_q <= taken_q + 1'b1;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o && !bit_ready_i |=> bit_valid_o && $stable(bit_o));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(taken_q) == LAST) && $past(bit_ready_i));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !(bit_ready_i && taken_q == LAST) |=> busy_o);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !bit_valid_o);
endmodule

bind tok_sof_builder tsb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .bit_o      (bit_o),
  .bit_valid_o(bit_valid_o),
  .bit_ready_i(bit_ready_i)
);

// File: tb/tok_sof_builder_tb.sv
module tok_sof_builder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] pkt_type = 4'h0;
  logic [6:0] addr = 7'h0;
  logic [3:0] endp = 4'h0;
  logic [10:0] frame = 11'h0;
  logic busy, err, bit_out, valid;
  logic ready = 1'b0;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tok_sof_builder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pkt_type_i(pkt_type),
    .addr_i(addr), .endp_i(endp), .frame_i(frame), .busy_o(busy),
    .err_o(err), .bit_o(bit_out), .bit_valid_o(valid), .bit_ready_i(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal_type(input logic [3:0] t);
    return (t == 4'h1) || (t == 4'h9) || (t == 4'hD) || (t == 4'h5);
  endfunction

  function automatic logic [23:0] expect_stream(input logic [3:0] t, input logic [6:0] a,
                                                input logic [3:0] e, input logic [10:0] f);
    logic [23:0] s;
    logic [10:0] p;
    logic [4:0] c;
    logic fb;
    p = (t == 4'h5) ? f : {e, a};
    s[7:0] = {~t, t};
    s[18:8] = p;
    c = 5'h1f;
    for (int i = 0; i < 11; i++) begin
      fb = c[4] ^ p[i];
      c = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
    end
    for (int j = 0; j < 5; j++) s[19 + j] = ~c[4 - j];
    return s;
  endfunction

  task automatic run_pkt(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e,
                         input logic [10:0] f, input int mode);
    logic [23:0] exp, got;
    int idx, guard;
    bit stall;
    logic sbit;
    exp = expect_stream(t, a, e, f);
    got = '0;
    @(negedge clk);
    pkt_type = t; addr = a; endp = e; frame = f; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    chk(busy && valid, "R7", "busy/valid after start", {busy, valid}, 2'b11);
    // R10 / R8: disturb inputs and keep requesting during the packet
    pkt_type = 4'h9; addr = ~a; endp = ~e; frame = ~f; start = 1'b1;
    idx = 0; guard = 0; stall = 1'b0; sbit = 1'b0;
    while (idx < 24 && guard < 400) begin
      case (mode)
        0: ready = 1'b1;
        1: ready = 1'($urandom % 2);
        default: ready = 1'(guard % 2);
      endcase
      if (stall) chk(valid && bit_out == sbit, "R6", "held bit under stall", {valid, bit_out}, {1'b1, sbit});
      if (valid && ready) begin
        got[idx] = bit_out;
        idx++;
        stall = 1'b0;
      end else begin
        stall = valid;
        sbit = bit_out;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0; ready = 1'b0;
    chk(idx == 24, "R7", "bits delivered", idx, 24);
    chk(!busy && !valid, "R8", "idle after last bit with start held", {busy, valid}, 2'b00);
    chk(got[7:0] == exp[7:0], "R2", "identifier byte", got[7:0], exp[7:0]);
    if (t == 4'h5) chk(got[18:8] == exp[18:8], "R4", "frame number", got[18:8], exp[18:8]);
    else           chk(got[18:8] == exp[18:8], "R3", "address/endpoint", got[18:8], exp[18:8]);
    chk(got[23:19] == exp[23:19], "R5", "check code", got[23:19], exp[23:19]);
    chk(got == exp, "R10", "whole packet", got, exp);
  endtask

  task automatic bad_type(input logic [3:0] t);
    @(negedge clk);
    pkt_type = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && !valid, "R9", "error pulse", {err, busy, valid}, 3'b100);
    @(negedge clk);
    chk(!err && !busy && !valid, "R9", "error clears", {err, busy, valid}, 3'b000);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !valid && !err, "R1", "reset state", {busy, valid, err}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !valid && !err, "R1", "state after reset release", {busy, valid, err}, 3'b000);
    for (int t = 0; t < 16; t++) begin
      if (!legal_type(4'(t))) bad_type(4'(t));
    end
    for (int a = 0; a < 128; a++) begin
      run_pkt(4'h1, 7'(a), 4'(a ^ 5), 11'h0, a % 3);
    end
    for (int e = 0; e < 16; e++) begin
      run_pkt(4'h9, 7'(e * 9), 4'(e), 11'h0, e % 3);
      run_pkt(4'hD, 7'(127 - e), 4'(15 - e), 11'h0, (e + 1) % 3);
    end
    run_pkt(4'h9, 7'h7f, 4'hf, 11'h0, 1);
    run_pkt(4'hD, 7'h00, 4'h0, 11'h0, 2);
    for (int k = 0; k < 64; k++) begin
      run_pkt(4'h5, 7'(k), 4'(k), 11'(k * 33 + (k << 5)), k % 3);
    end
    run_pkt(4'h5, 7'h55, 4'ha, 11'h000, 0);
    run_pkt(4'h5, 7'h2a, 4'h5, 11'h7ff, 1);
    bad_type(4'h0);
    bad_type(4'hf);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule